// File: doc/BRIEF.md
# Data-Strobe Serial Character Transmitter

This block is the sending half of a two-wire serial link in which the receiver recovers the bit clock from a data line and a strobe line. A client hands it one character at a time over a valid/ready interface. A character is either an 8-bit data byte or a 2-bit control code, such as end-of-packet. The block serialises each character behind a parity bit and a data/control flag, so that characters differ in length. A packet is a header, then one or more data bytes, then an end-of-packet control character. The packet structure belongs to the client; the transmitter only moves characters.

The bit period comes from a digital prescaler that divides the single reference clock, with no PLL. A 2-bit select picks one of four divisors. With a 100 MHz reference, the default divisors give 5, 10, 50 and 100 Mb/s. A new select value takes effect only where one character ends and the next begins. When the client has nothing to send, the block fills the line with null characters, each an escape code followed by a flow-control token.

The sequencer has four states:
- `ST_START` holds after reset.
- `ST_PARITY` means the parity bit is on the wire.
- `ST_FLAG` means the flag is on the wire.
- `ST_BODY` means payload bits are on the wire.

Transitions happen only on a prescaler tick:
- START→PARITY: first character loaded.
- PARITY→FLAG.
- FLAG→BODY.
- BODY→BODY: payload bits remain.
- BODY→PARITY: last payload bit done, next character loaded.

Top module: `ds_char_tx`

## Requirements
- R1: A data character is sent as a parity bit, then a flag of 0, then the 8 data bits least significant first: 10 bit periods.
- R2: A control character is sent as a parity bit, then a flag of 1, then a 2-bit code with bit 0 first: 4 bit periods. The codes are 00 flow-control token, 01 end-of-packet, 10 error end-of-packet and 11 escape.
- R3: The parity bit is chosen so that the following bits hold an odd number of ones: the payload bits of the preceding character, the parity bit itself and the flag. For the first character after reset, the preceding payload counts as empty.
- R4: During reset both `ds_data` and `ds_strobe` are 0. Every bit period starts with exactly one of the two lines changing: `ds_data` when the new bit differs from the last one, otherwise `ds_strobe`.
- R5: When no character is offered at a character boundary, a null is sent: escape (11) immediately followed by flow-control token (00). A client character is never placed between the two halves of a null.
- R6: `in_ready` is high for single cycles only, at a character boundary. A character is taken when `in_valid` and `in_ready` are both high, and the line starts its parity bit in the next cycle. Accepted characters appear on the line in order, with none lost.
- R7: Every bit period lasts exactly the divisor picked by `rate_sel`, measured in reference-clock cycles: 0→`DIV_R0`, 1→`DIV_R1`, 2→`DIV_R2`, 3→`DIV_R3`.
- R8: The divisor is sampled only at a character boundary. All bits of one character, including its last payload bit, have the same period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_sel | input | 2 | Bit-rate select, sampled at character boundaries |
| in_valid | input | 1 | Client offers a character |
| in_is_ctrl | input | 1 | 1: control character (code in `in_data[1:0]`), 0: data byte |
| in_data | input | 8 | Data byte or control code |
| in_ready | output | 1 | Character taken this cycle when `in_valid` is high |
| ds_data | output | 1 | Serial data line |
| ds_strobe | output | 1 | Strobe line, toggles when data repeats |

## Verification
The bench builds the block with divisors 7, 4, 2 and 1. Every rate, including an odd divisor and the one-cycle bit period, is then reached within a few hundred cycles. At the fastest rate the bench sweeps all 256 byte values. It also sends both kinds of end-of-packet and leaves idle gaps that fill with nulls. Finally, it moves the rate select every few cycles while characters stream back to back. This puts rate changes at arbitrary points inside characters, where any bit period that stretches or shrinks mid-character is detected.

// File: rtl/dstx_pkg.sv
package dstx_pkg;

    localparam int DATA_W = 8;
    localparam int CODE_W = 2;

    localparam logic [CODE_W-1:0] CODE_FCT = 2'b00;
    localparam logic [CODE_W-1:0] CODE_EOP = 2'b01;
    localparam logic [CODE_W-1:0] CODE_EEP = 2'b10;
    localparam logic [CODE_W-1:0] CODE_ESC = 2'b11;

    typedef enum logic [1:0] {
        ST_START  = 2'd0,
        ST_PARITY = 2'd1,
        ST_FLAG   = 2'd2,
        ST_BODY   = 2'd3
    } tx_state_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dstx_prescaler.sv
module dstx_prescaler #(
    parameter int DIV_R0 = 20,
    parameter int DIV_R1 = 10,
    parameter int DIV_R2 = 2,
    parameter int DIV_R3 = 1,
    parameter int CW     = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    rate_sel,
    input  logic          boundary,
    output logic          tick,
    output logic [CW-1:0] cur_div
);

    localparam int DIVS [4] = '{DIV_R0, DIV_R1, DIV_R2, DIV_R3};

    logic [CW-1:0] div_tab [4];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] div_q;

    for (genvar g = 0; g < 4; g++) begin : g_tab
        assign div_tab[g] = CW'(DIVS[g]);
    end

    assign tick    = (cnt_q == '0);
    assign cur_div = div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            div_q <= div_tab[0];
        end else if (tick) begin
            if (boundary) begin
                div_q <= div_tab[rate_sel];
                cnt_q <= div_tab[rate_sel] - 1'b1;
            end else begin
                cnt_q <= div_q - 1'b1;
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/dstx_line_enc.sv
module dstx_line_enc (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bit_in,
    output logic ds_data,
    output logic ds_strobe
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_data   <= 1'b0;
            ds_strobe <= 1'b0;
        end else if (tick) begin
            ds_data <= bit_in;
            if (bit_in == ds_data) begin
                ds_strobe <= ~ds_strobe;
            end
        end
    end

endmodule

// File: rtl/ds_char_tx.sv
module ds_char_tx
    import dstx_pkg::*;
#(
    parameter int DIV_R0 = 20,
    parameter int DIV_R1 = 10,
    parameter int DIV_R2 = 2,
    parameter int DIV_R3 = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate_sel,
    input  logic              in_valid,
    input  logic              in_is_ctrl,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              ds_data,
    output logic              ds_strobe
);

    localparam int CW    = $clog2(max4(DIV_R0, DIV_R1, DIV_R2, DIV_R3) + 1);
    localparam int CNT_W = $clog2(DATA_W);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shreg_q;
    logic              is_ctrl_q;
    logic              win_par_q;
    logic              null_pend;

    logic              tick;
    logic              boundary;
    logic [CW-1:0]     cur_div;
    logic              tx_bit;
    logic              new_ctrl;
    logic [DATA_W-1:0] new_pay;

    dstx_prescaler #(
        .DIV_R0(DIV_R0), .DIV_R1(DIV_R1), .DIV_R2(DIV_R2), .DIV_R3(DIV_R3), .CW(CW)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .rate_sel (rate_sel),
        .boundary (boundary),
        .tick     (tick),
        .cur_div  (cur_div)
    );

    dstx_line_enc u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bit_in    (tx_bit),
        .ds_data   (ds_data),
        .ds_strobe (ds_strobe)
    );

    assign boundary = tick && ((state_q == ST_START) ||
                               (state_q == ST_BODY && cnt_q == '0));
    assign in_ready = boundary && !null_pend;

    // Next character: second half of a null, client character, or a null start
    always_comb begin
        if (null_pend) begin
            new_ctrl = 1'b1;
            new_pay  = DATA_W'(CODE_FCT);
        end else if (in_valid) begin
            new_ctrl = in_is_ctrl;
            new_pay  = in_is_ctrl ? DATA_W'(in_data[CODE_W-1:0]) : in_data;
        end else begin
            new_ctrl = 1'b1;
            new_pay  = DATA_W'(CODE_ESC);
        end
    end

    // Bit placed on the line at this tick
    always_comb begin
        unique case (state_q)
            ST_PARITY: tx_bit = is_ctrl_q;
            ST_FLAG:   tx_bit = shreg_q[0];
            ST_START:  tx_bit = 1'b1 ^ win_par_q ^ new_ctrl;
            ST_BODY:   tx_bit = (cnt_q == '0) ? (1'b1 ^ win_par_q ^ new_ctrl) : shreg_q[0];
        endcase
    end

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                ST_START:  state_d = ST_PARITY;
                ST_PARITY: state_d = ST_FLAG;
                ST_FLAG:   state_d = ST_BODY;
                ST_BODY:   state_d = (cnt_q == '0) ? ST_PARITY : ST_BODY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_START;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            shreg_q   <= '0;
            is_ctrl_q <= 1'b0;
            win_par_q <= 1'b0;
            null_pend <= 1'b0;
        end else if (tick) begin
            if (boundary) begin
                is_ctrl_q <= new_ctrl;
                shreg_q   <= new_pay;
                win_par_q <= 1'b0;
                null_pend <= null_pend ? 1'b0 : !in_valid;
            end else if (state_q == ST_FLAG) begin
                cnt_q     <= is_ctrl_q ? CNT_W'(CODE_W - 1) : CNT_W'(DATA_W - 1);
                shreg_q   <= shreg_q >> 1;
                win_par_q <= win_par_q ^ shreg_q[0];
            end else if (state_q == ST_BODY) begin
                cnt_q     <= cnt_q - 1'b1;
                shreg_q   <= shreg_q >> 1;
                win_par_q <= win_par_q ^ shreg_q[0];
            end
        end
    end

endmodule

// File: rtl/dstx_chk.sv
module dstx_chk #(
    parameter int W = 5
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ds_data,
    input logic         ds_strobe,
    input logic         in_ready,
    input logic         boundary,
    input logic [W-1:0] cur_div
);

    // R4
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_data != $past(ds_data)) |-> (ds_strobe == $past(ds_strobe)));

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    // R6
    accept_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> ((ds_data != $past(ds_data)) || (ds_strobe != $past(ds_strobe))));

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(cur_div));

endmodule

bind ds_char_tx dstx_chk #(.W(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ds_data   (ds_data),
    .ds_strobe (ds_strobe),
    .in_ready  (in_ready),
    .boundary  (boundary),
    .cur_div   (cur_div)
);

// File: tb/sim_ds_char_tx.sv
module sim_ds_char_tx;

    localparam int CLK_NS = 10;
    localparam int D0 = 7;
    localparam int D1 = 4;
    localparam int D2 = 2;
    localparam int D3 = 1;
    localparam int DIVS [4] = '{D0, D1, D2, D3};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic       in_valid = 1'b0;
    logic       in_is_ctrl = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       ds_data;
    logic       ds_strobe;

    int tests = 0;
    int fails = 0;

    always #(CLK_NS/2) clk = ~clk;

    ds_char_tx #(.DIV_R0(D0), .DIV_R1(D1), .DIV_R2(D2), .DIV_R3(D3)) u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .in_valid(in_valid), .in_is_ctrl(in_is_ctrl), .in_data(in_data),
        .in_ready(in_ready), .ds_data(ds_data), .ds_strobe(ds_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected characters {ctrl, byte}
    logic [8:0] expq [0:511];
    int widx = 0;
    int ridx = 0;

    // Line monitor / decoder state
    logic pd = 1'b0, ps = 1'b0;
    int   cyc = 0, last = 0, chdur = 0;
    bit   started = 0, want_on = 0;
    int   want_div = 0;
    int   pst = 0, need = 0, nbits = 0, null_cnt = 0;
    logic win = 1'b0, flg = 1'b0;
    logic [7:0] pay = 8'h00;
    bit   esc_pend = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ds_data != pd || ds_strobe != ps) begin
                int d;
                logic b;
                check(!(ds_data != pd && ds_strobe != ps), "R4 one line per bit", 2, 1);
                d = cyc - last;
                last = cyc;
                b = ds_data;
                if (pst == 1) begin
                    chdur = d;
                    started = 1;
                    if (want_on) check(d == want_div, "R7 bit period", d, want_div);
                end else if (started) begin
                    check(d == chdur, "R8 period within character", d, chdur);
                end
                if (pst == 0) begin
                    win = win ^ b;
                    pst = 1;
                end else if (pst == 1) begin
                    win = win ^ b;
                    check(win == 1'b1, "R3 odd parity", int'(win), 1);
                    win = 1'b0;
                    flg = b;
                    need = b ? 2 : 8;
                    nbits = 0;
                    pay = 8'h00;
                    pst = 2;
                end else begin
                    win = win ^ b;
                    pay[nbits] = b;
                    nbits++;
                    if (nbits == need) begin
                        pst = 0;
                        if (flg && pay[1:0] == 2'b11) begin
                            check(!esc_pend, "R5 escape without token", 3, 0);
                            esc_pend = 1;
                        end else if (flg && pay[1:0] == 2'b00 && esc_pend) begin
                            null_cnt++;
                            esc_pend = 0;
                        end else begin
                            check(!esc_pend, "R5 null split by character", int'(pay), 0);
                            esc_pend = 0;
                            if (ridx >= widx) begin
                                check(0, "R6 unexpected character", int'({flg, pay}), -1);
                            end else begin
                                logic [8:0] e;
                                e = expq[ridx];
                                ridx++;
                                if (e[8]) check(flg && pay[1:0] == e[1:0], "R2 control code",
                                                int'({flg, pay}), int'(e));
                                else check(!flg && pay == e[7:0], "R1 data byte",
                                           int'({flg, pay}), int'(e));
                            end
                        end
                    end
                end
            end
            pd = ds_data;
            ps = ds_strobe;
        end
    end

    task automatic send(input logic c, input logic [7:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        in_is_ctrl = c;
        in_data = v;
        while (!in_ready) @(negedge clk);
        expq[widx] = {c, v};
        widx++;
        @(negedge clk);
        check(!in_ready, "R6 ready single cycle", 1, 0);
        in_valid = 1'b0;
    endtask

    bit done = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R4 reset levels
        check(ds_data == 1'b0 && ds_strobe == 1'b0, "R4 reset levels",
              int'({ds_data, ds_strobe}), 0);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        // R5 idle fills with nulls
        check(null_cnt > 0, "R5 nulls while idle", null_cnt, 1);

        for (int r = 0; r < 4; r++) begin
            want_on = 0;
            rate_sel = 2'(r);
            repeat (40 * D0) @(negedge clk);
            want_div = DIVS[r];
            want_on = 1;
            send(1'b0, 8'(8'h10 + r));
            if (r == 3) begin
                for (int v = 0; v < 256; v++) send(1'b0, 8'(v));
            end else begin
                for (int k = 0; k < 8; k++) send(1'b0, 8'(8'h01 << k) ^ 8'(r * 8'h35));
            end
            send(1'b1, (r % 2 == 0) ? 8'h01 : 8'h02);
            repeat (30) @(negedge clk);
        end

        // R8 rate moved mid-character while streaming
        want_on = 0;
        fork
            begin
                for (int k = 0; k < 24; k++) send(1'b0, 8'(k * 37));
                send(1'b1, 8'h01);
            end
            begin
                for (int k = 0; k < 60; k++) begin
                    repeat (13) @(negedge clk);
                    rate_sel = 2'(k % 4);
                end
            end
        join

        repeat (600) @(negedge clk);
        // R6 all accepted characters arrived in order
        check(ridx == widx, "R6 characters delivered", ridx, widx);
        check(null_cnt > 2, "R5 nulls between packets", null_cnt, 3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule